// File: doc/BRIEF.md
# Circular-Buffer Byte Transmit DMA Channel

This block is one memory-to-device DMA channel. It feeds a byte-wide serial transmitter from a circular buffer held in memory. Software uses a 32-bit register port to set the buffer's base address, the ring length, an interrupt level and an optional top address bit. It then moves a write pointer forward to hand bytes over. The channel reads one byte at a time from memory, starting at its read pointer. It presents each byte on a valid/ready stream and advances the read pointer when the stream accepts the byte. It stops when the two pointers are equal.

Each pointer holds an offset plus a wrap flag just above it, so a full ring and an empty ring are never confused. Software can halt the channel cleanly with a request/acknowledge sequence, ask for the pending data to drain through a self-clearing bit, or warm-reset the channel without touching the system reset. An interrupt tells software when enough free space has opened up in the ring.

Top module: `txring_dma`

## Requirements
- R1: Register byte offsets: enable 0x00, halt 0x04, drain 0x08, warm reset 0x0C, interrupt enable 0x10, interrupt flag 0x14, base 0x18, address extension 0x1C, ring length 0x20, interrupt level 0x24, write pointer 0x28, read pointer 0x2C (read-only), pending count 0x30 (read-only), free room 0x34 (read-only), debug state 0x38 (read-only). Single-bit controls live in bit 0. Reads are combinational.
- R2: A pointer is OFF_W+1 bits wide: the offset in bits [OFF_W-1:0] and the wrap flag in bit OFF_W. A write to the write pointer whose offset equals the ring length is stored as offset 0 with the wrap flag inverted. Any other value is stored unchanged.
- R3: The pending count is the write offset minus the read offset, plus the ring length when the two wrap flags differ. The free room is the ring length minus the pending count.
- R4: A memory read is issued only while enable is 1, halt is 0 and pending is non-zero. Its address is the extension bit concatenated above (base + read offset) modulo 2^AW.
- R5: Bytes leave in ring order. The read pointer advances by one on each stream handshake, and past the last offset it returns to offset 0 with the wrap flag inverted.
- R6: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays stable.
- R7: At most one memory read is outstanding, and mem_req is never high in two consecutive cycles.
- R8: The interrupt flag is set in any cycle where enable is 1 and room is at least the interrupt level. Writing 0 to bit 0 of the flag register clears it, but setting takes priority over clearing. The irq output is the flag ANDed with interrupt enable.
- R9: While halt is 1, a byte already presented stays until it is accepted. Once the engine is idle, enable drops to 0. Enable stays 0 after halt is written back to 0.
- R10: Writing 1 to the drain bit sets it. It reads 1 while bytes are pending and the channel is enabled, and clears itself once the engine is idle with nothing pending or with enable at 0.
- R11: Writing 1 to the warm-reset bit clears enable, halt, drain, the interrupt flag and both pointers within a few cycles, and drops any presented byte. It never interrupts a memory read that is still waiting for its response.
- R12: After rst_n, enable, both pointers, irq, tx_valid and mem_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | AW+1 | Read byte address, with the extension bit on top |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 8 | Memory response byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_ready | input | 1 | Stream ready from the transmitter |
| irq | output | 1 | Free-room interrupt |

## Verification
The bench builds the channel with OFF_W=8 and AW=12. With these values the wrap flag sits at bit 8, and an 8-entry ring with base 0xFFC pushes base+offset past the top of the 12-bit address space. The address rollover and the pointer wrap flip both occur within a few dozen bytes. A vector table covers pointer normalisation and the pending/room arithmetic. Directed runs then cover ordered wrap-around delivery, the halt sequence with a stalled stream, drain self-clear, the extension bit, fetch gating and warm reset in the middle of a transfer.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int REG_AW = 8;
    localparam int REG_W  = 32;

    localparam logic [REG_AW-1:0] A_ENABLE   = 8'h00;
    localparam logic [REG_AW-1:0] A_HALT     = 8'h04;
    localparam logic [REG_AW-1:0] A_DRAIN    = 8'h08;
    localparam logic [REG_AW-1:0] A_WRST     = 8'h0C;
    localparam logic [REG_AW-1:0] A_IRQ_EN   = 8'h10;
    localparam logic [REG_AW-1:0] A_IRQ_FLAG = 8'h14;
    localparam logic [REG_AW-1:0] A_BASE     = 8'h18;
    localparam logic [REG_AW-1:0] A_ADDR_HI  = 8'h1C;
    localparam logic [REG_AW-1:0] A_RLEN     = 8'h20;
    localparam logic [REG_AW-1:0] A_LEVEL    = 8'h24;
    localparam logic [REG_AW-1:0] A_WPTR     = 8'h28;
    localparam logic [REG_AW-1:0] A_RPTR     = 8'h2C;
    localparam logic [REG_AW-1:0] A_PEND     = 8'h30;
    localparam logic [REG_AW-1:0] A_ROOM     = 8'h34;
    localparam logic [REG_AW-1:0] A_DBG      = 8'h38;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2,
        FS_SEND = 2'd3
    } fetch_state_e;

endpackage

// File: rtl/txring_ring.sv
// Combinational ring arithmetic: occupancy, free room, next read pointer.
module txring_ring #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W:0]   wr_ptr,
    input  logic [OFF_W:0]   rd_ptr,
    input  logic [OFF_W-1:0] rlen,
    output logic [OFF_W-1:0] pending,
    output logic [OFF_W-1:0] room,
    output logic [OFF_W:0]   rd_inc
);
    logic [OFF_W:0] diff;
    logic [OFF_W:0] step;

    always_comb begin
        diff = {1'b0, wr_ptr[OFF_W-1:0]} - {1'b0, rd_ptr[OFF_W-1:0]};
        if (wr_ptr[OFF_W] != rd_ptr[OFF_W]) begin
            diff = diff + {1'b0, rlen};
        end
        pending = diff[OFF_W-1:0];
        room    = rlen - diff[OFF_W-1:0];

        step = {1'b0, rd_ptr[OFF_W-1:0]} + {{OFF_W{1'b0}}, 1'b1};
        if (step == {1'b0, rlen}) begin
            rd_inc = {~rd_ptr[OFF_W], {OFF_W{1'b0}}};
        end else begin
            rd_inc = {rd_ptr[OFF_W], step[OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/txring_fetch.sv
// One-byte-at-a-time fetch engine: request, wait for response, present on stream.
module txring_fetch
    import txring_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       abort,
    input  logic       mem_rvalid,
    input  logic [7:0] mem_rdata,
    input  logic       tx_ready,
    output logic       mem_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       advance,
    output logic       idle,
    output logic       mem_busy,
    output logic [1:0] state_o
);
    typedef struct packed {
        fetch_state_e state;
        logic [7:0]   data;
    } fetch_s;

    fetch_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            FS_IDLE: if (go) f_d.state = FS_REQ;
            FS_REQ:  f_d.state = FS_WAIT;
            FS_WAIT: begin
                if (mem_rvalid) begin
                    f_d.state = FS_SEND;
                    f_d.data  = mem_rdata;
                end
            end
            FS_SEND: if (tx_ready) f_d.state = FS_IDLE;
            default: f_d.state = FS_IDLE;
        endcase
        if (abort) begin
            f_d.state = FS_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{state: FS_IDLE, data: 8'h00};
        end else begin
            f_q <= f_d;
        end
    end

    assign mem_req  = (f_q.state == FS_REQ);
    assign tx_valid = (f_q.state == FS_SEND);
    assign tx_data  = f_q.data;
    assign advance  = (f_q.state == FS_SEND) && tx_ready && !abort;
    assign idle     = (f_q.state == FS_IDLE);
    assign mem_busy = (f_q.state == FS_REQ) || (f_q.state == FS_WAIT);
    assign state_o  = f_q.state;
endmodule

// File: rtl/txring_regs.sv
// Control and pointer registers with halt, drain, warm-reset and interrupt logic.
module txring_regs
    import txring_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [OFF_W-1:0]  pending,
    input  logic [OFF_W-1:0]  room,
    input  logic [OFF_W:0]    rd_inc,
    input  logic              advance,
    input  logic              fetch_idle,
    input  logic              mem_busy,
    output logic              en,
    output logic              halt,
    output logic              drain,
    output logic              irq_en,
    output logic              irq_flag,
    output logic              ext,
    output logic [AW-1:0]     base,
    output logic [OFF_W-1:0]  rlen,
    output logic [OFF_W-1:0]  level,
    output logic [OFF_W:0]    wptr,
    output logic [OFF_W:0]    rptr,
    output logic              wrst_pend,
    output logic              wrst_apply,
    output logic              go
);
    typedef struct packed {
        logic             en;
        logic             halt;
        logic             drain;
        logic             irq_en;
        logic             irq_flag;
        logic             ext;
        logic [AW-1:0]    base;
        logic [OFF_W-1:0] rlen;
        logic [OFF_W-1:0] level;
        logic [OFF_W:0]   wptr;
        logic [OFF_W:0]   rptr;
        logic             wrst_pend;
    } regs_s;

    regs_s r_d, r_q;
    logic [OFF_W:0] wr_norm;

    always_comb begin
        if (reg_wdata[OFF_W-1:0] == r_q.rlen) begin
            wr_norm = {~reg_wdata[OFF_W], {OFF_W{1'b0}}};
        end else begin
            wr_norm = reg_wdata[OFF_W:0];
        end
    end

    always_comb begin
        r_d        = r_q;
        wrst_apply = r_q.wrst_pend && !mem_busy;

        if (reg_wr) begin
            case (reg_addr)
                A_ENABLE:   r_d.en     = reg_wdata[0];
                A_HALT:     r_d.halt   = reg_wdata[0];
                A_DRAIN:    if (reg_wdata[0]) r_d.drain = 1'b1;
                A_WRST:     if (reg_wdata[0]) r_d.wrst_pend = 1'b1;
                A_IRQ_EN:   r_d.irq_en = reg_wdata[0];
                A_IRQ_FLAG: if (!reg_wdata[0]) r_d.irq_flag = 1'b0;
                A_BASE:     r_d.base   = reg_wdata[AW-1:0];
                A_ADDR_HI:  r_d.ext    = reg_wdata[0];
                A_RLEN:     r_d.rlen   = reg_wdata[OFF_W-1:0];
                A_LEVEL:    r_d.level  = reg_wdata[OFF_W-1:0];
                A_WPTR:     r_d.wptr   = wr_norm;
                default: ;
            endcase
        end

        if (advance) begin
            r_d.rptr = rd_inc;
        end

        if (r_q.halt && fetch_idle) begin
            r_d.en = 1'b0;
        end

        if (r_q.drain && fetch_idle && ((pending == '0) || !r_q.en)) begin
            r_d.drain = 1'b0;
        end

        if (r_q.en && (room >= r_q.level)) begin
            r_d.irq_flag = 1'b1;
        end

        if (wrst_apply) begin
            r_d.en        = 1'b0;
            r_d.halt      = 1'b0;
            r_d.drain     = 1'b0;
            r_d.irq_flag  = 1'b0;
            r_d.wptr      = '0;
            r_d.rptr      = '0;
            r_d.wrst_pend = 1'b0;
        end

        go = r_q.en && !r_q.halt && (pending != '0) && !r_q.wrst_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en        = r_q.en;
    assign halt      = r_q.halt;
    assign drain     = r_q.drain;
    assign irq_en    = r_q.irq_en;
    assign irq_flag  = r_q.irq_flag;
    assign ext       = r_q.ext;
    assign base      = r_q.base;
    assign rlen      = r_q.rlen;
    assign level     = r_q.level;
    assign wptr      = r_q.wptr;
    assign rptr      = r_q.rptr;
    assign wrst_pend = r_q.wrst_pend;
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int AW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_req,
    output logic [AW:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int PAD_W = AW - OFF_W;

    logic             en_w, halt_w, drain_w, irq_en_w, irq_flag_w, ext_w;
    logic [AW-1:0]    base_w;
    logic [OFF_W-1:0] rlen_w, level_w, pending_w, room_w;
    logic [OFF_W:0]   wptr_w, rptr_w, rd_inc_w;
    logic             wrst_pend_w, wrst_apply_w, go_w;
    logic             advance_w, idle_w, mem_busy_w;
    logic [1:0]       fstate_w;

    txring_ring #(.OFF_W(OFF_W)) u_ring (
        .wr_ptr  (wptr_w),
        .rd_ptr  (rptr_w),
        .rlen    (rlen_w),
        .pending (pending_w),
        .room    (room_w),
        .rd_inc  (rd_inc_w)
    );

    txring_regs #(.OFF_W(OFF_W), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pending    (pending_w),
        .room       (room_w),
        .rd_inc     (rd_inc_w),
        .advance    (advance_w),
        .fetch_idle (idle_w),
        .mem_busy   (mem_busy_w),
        .en         (en_w),
        .halt       (halt_w),
        .drain      (drain_w),
        .irq_en     (irq_en_w),
        .irq_flag   (irq_flag_w),
        .ext        (ext_w),
        .base       (base_w),
        .rlen       (rlen_w),
        .level      (level_w),
        .wptr       (wptr_w),
        .rptr       (rptr_w),
        .wrst_pend  (wrst_pend_w),
        .wrst_apply (wrst_apply_w),
        .go         (go_w)
    );

    txring_fetch u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go_w),
        .abort      (wrst_apply_w),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .tx_ready   (tx_ready),
        .mem_req    (mem_req),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .advance    (advance_w),
        .idle       (idle_w),
        .mem_busy   (mem_busy_w),
        .state_o    (fstate_w)
    );

    assign mem_addr = {ext_w, base_w + {{PAD_W{1'b0}}, rptr_w[OFF_W-1:0]}};
    assign irq      = irq_flag_w && irq_en_w;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE:   reg_rdata = REG_W'(en_w);
            A_HALT:     reg_rdata = REG_W'(halt_w);
            A_DRAIN:    reg_rdata = REG_W'(drain_w);
            A_IRQ_EN:   reg_rdata = REG_W'(irq_en_w);
            A_IRQ_FLAG: reg_rdata = REG_W'(irq_flag_w);
            A_BASE:     reg_rdata = REG_W'(base_w);
            A_ADDR_HI:  reg_rdata = REG_W'(ext_w);
            A_RLEN:     reg_rdata = REG_W'(rlen_w);
            A_LEVEL:    reg_rdata = REG_W'(level_w);
            A_WPTR:     reg_rdata = REG_W'(wptr_w);
            A_RPTR:     reg_rdata = REG_W'(rptr_w);
            A_PEND:     reg_rdata = REG_W'(pending_w);
            A_ROOM:     reg_rdata = REG_W'(room_w);
            A_DBG:      reg_rdata = REG_W'({fstate_w, wrst_pend_w, halt_w, en_w});
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
    parameter int OFF_W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tx_valid,
    input logic           tx_ready,
    input logic [7:0]     tx_data,
    input logic           mem_req,
    input logic           en,
    input logic [OFF_W:0] rptr,
    input logic           wrst_apply
);
    // R6
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wrst_apply) |=> (tx_valid && $stable(tx_data)));

    // R7
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R4
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(en));

    // R5
    rptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tx_valid && tx_ready) && !wrst_apply) |=> $stable(rptr));

    // R5
    rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wrst_apply) |=> (rptr != $past(rptr)));
endmodule

bind txring_dma txring_dma_chk #(.OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .mem_req    (mem_req),
    .en         (en_w),
    .rptr       (rptr_w),
    .wrst_apply (wrst_apply_w)
);

// File: tb/txring_dma_bench.sv
`timescale 1ns/1ps
module txring_dma_bench;
    import txring_pkg::*;

    localparam int OFF_W = 8;
    localparam int AW    = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_wr;
    logic [REG_AW-1:0] reg_addr;
    logic [REG_W-1:0]  reg_wdata;
    logic [REG_W-1:0]  reg_rdata;
    logic              mem_req;
    logic [AW:0]       mem_addr;
    logic              mem_rvalid;
    logic [7:0]        mem_rdata;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready;
    logic              irq;

    always #2 clk = ~clk;

    txring_dma #(.OFF_W(OFF_W), .AW(AW)) u_txring_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    // memory model: response two edges after the request
    logic        m_pend;
    logic [AW:0] m_addr;
    logic [AW:0] last_addr;
    int          nreq;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend <= 1'b0; m_addr <= '0; mem_rvalid <= 1'b0; mem_rdata <= 8'h00;
            nreq <= 0; last_addr <= '0;
        end else begin
            mem_rvalid <= 1'b0;
            if (m_pend) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= m_addr[7:0] ^ 8'hA5;
                m_pend     <= 1'b0;
            end
            if (mem_req) begin
                m_pend    <= 1'b1;
                m_addr    <= mem_addr;
                last_addr <= mem_addr;
                nreq      <= nreq + 1;
            end
        end
    end

    logic [7:0] got [0:63];
    int         ngot;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ngot <= 0;
        else if (tx_valid && tx_ready) begin
            got[ngot[5:0]] <= tx_data;
            ngot <= ngot + 1;
        end
    end

    int total = 0;
    int fails = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_cnt(input int n);
        for (int k = 0; k < 500 && ngot < n; k++) @(negedge clk);
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 100 && !tx_valid; k++) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int off);
        logic [AW-1:0] a;
        a = 12'hFFC + 12'(off);
        return a[7:0] ^ 8'hA5;
    endfunction

    // write value, expected stored pointer, expected pending (ring length 8)
    localparam logic [31:0] VEC [0:5][0:2] = '{
        '{32'h000, 32'h000, 32'd0},
        '{32'h003, 32'h003, 32'd3},
        '{32'h008, 32'h100, 32'd8},
        '{32'h005, 32'h005, 32'd5},
        '{32'h100, 32'h100, 32'd8},
        '{32'h108, 32'h000, 32'd0}
    };

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          snap;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(A_ENABLE, v); chk("R12 enable", v, 0);
        rd(A_WPTR, v);   chk("R12 write pointer", v, 0);
        rd(A_RPTR, v);   chk("R12 read pointer", v, 0);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 tx_valid", 32'(tx_valid), 0);
        chk("R12 mem_req", 32'(mem_req), 0);

        // R1 R2 R3 vector table, channel disabled
        wr(A_RLEN, 8);
        for (int i = 0; i < 6; i++) begin
            wr(A_WPTR, VEC[i][0]);
            rd(A_WPTR, v);  chk("R2 stored write pointer", v, VEC[i][1]);
            rd(A_PEND, v);  chk("R3 pending", v, VEC[i][2]);
            rd(A_ROOM, v);  chk("R3 room", v, 8 - VEC[i][2]);
        end

        // R4 R5 transfer with address rollover
        wr(A_BASE, 32'hFFC); wr(A_LEVEL, 8); wr(A_IRQ_EN, 1);
        tx_ready = 1'b1;
        wr(A_ENABLE, 1); wr(A_WPTR, 5);
        wait_cnt(5);
        for (int i = 0; i < 5; i++) chk("R4 R5 byte order", 32'(got[i]), 32'(exp_byte(i)));
        rd(A_RPTR, v); chk("R5 read pointer", v, 5);
        rd(A_PEND, v); chk("R3 drained", v, 0);
        chk("R8 irq when room reaches level", 32'(irq), 1);

        // R5 wrap of the read pointer
        wr(A_WPTR, 32'h103);
        wait_cnt(11);
        chk("R5 wrap byte 5", 32'(got[5]), 32'(exp_byte(5)));
        chk("R5 wrap byte 7", 32'(got[7]), 32'(exp_byte(7)));
        chk("R5 wrap byte 0", 32'(got[8]), 32'(exp_byte(0)));
        chk("R5 wrap byte 2", 32'(got[10]), 32'(exp_byte(2)));
        rd(A_RPTR, v); chk("R5 wrap flag flipped", v, 32'h103);

        // R8 clear and gating
        wr(A_ENABLE, 0);
        wr(A_IRQ_FLAG, 0);
        rd(A_IRQ_FLAG, v); chk("R8 flag cleared", v, 0);
        chk("R8 irq low", 32'(irq), 0);
        wr(A_IRQ_EN, 0);
        wr(A_ENABLE, 1);
        @(negedge clk);
        rd(A_IRQ_FLAG, v); chk("R8 flag set again", v, 1);
        chk("R8 irq masked", 32'(irq), 0);
        wr(A_IRQ_EN, 1);

        // R9 halt handshake
        tx_ready = 1'b0;
        wr(A_WPTR, 32'h106);
        wait_valid();
        wr(A_HALT, 1);
        repeat (2) @(negedge clk);
        rd(A_ENABLE, v); chk("R9 enable held during byte", v, 1);
        chk("R6 byte still presented", 32'(tx_valid), 1);
        tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_ENABLE, v); chk("R9 enable dropped", v, 0);
        rd(A_PEND, v);   chk("R9 pending kept", v, 2);
        snap = nreq;
        repeat (10) @(negedge clk);
        chk("R9 no fetch while halted", 32'(nreq), 32'(snap));
        wr(A_HALT, 0);
        rd(A_ENABLE, v); chk("R9 enable stays low", v, 0);

        // R10 drain
        tx_ready = 1'b0;
        wr(A_ENABLE, 1);
        wr(A_DRAIN, 1);
        rd(A_DRAIN, v); chk("R10 drain busy", v, 1);
        tx_ready = 1'b1;
        wait_cnt(14);
        repeat (3) @(negedge clk);
        rd(A_DRAIN, v); chk("R10 drain self-cleared", v, 0);
        rd(A_RPTR, v);  chk("R5 pointer after drain", v, 32'h106);
        chk("R5 drained byte 5", 32'(got[13]), 32'(exp_byte(5)));

        // R4 address extension bit
        wr(A_ADDR_HI, 1);
        wr(A_WPTR, 32'h107);
        wait_cnt(15);
        chk("R4 extension address", 32'(last_addr), 32'h1002);
        chk("R4 extension byte", 32'(got[14]), 32'(8'h02 ^ 8'hA5));

        // R4 gating by enable
        wr(A_ENABLE, 0);
        wr(A_WPTR, 32'h000);
        snap = nreq;
        repeat (20) @(negedge clk);
        chk("R4 no fetch when disabled", 32'(nreq), 32'(snap));
        rd(A_PEND, v); chk("R3 pending across wrap flags", v, 1);

        // R11 warm reset during a presented byte
        tx_ready = 1'b0;
        wr(A_ENABLE, 1);
        wait_valid();
        wr(A_WRST, 1);
        repeat (4) @(negedge clk);
        rd(A_ENABLE, v);   chk("R11 enable cleared", v, 0);
        rd(A_RPTR, v);     chk("R11 read pointer cleared", v, 0);
        rd(A_WPTR, v);     chk("R11 write pointer cleared", v, 0);
        rd(A_IRQ_FLAG, v); chk("R11 flag cleared", v, 0);
        chk("R11 byte dropped", 32'(tx_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule